// File: doc/BRIEF.md
# Basic Up-Counting Timer with Reload Buffering

This block is a general-purpose timer that counts up from zero at a rate set by a programmable prescaler. When the counter reaches the active reload limit, it wraps to zero and raises an update event. An update event pulses a trigger output for one cycle, sets a sticky status flag that can drive an interrupt, and copies the buffered prescaler and reload values into their active registers.

Software controls the block through a plain synchronous register port. The port has a combinational read path and a single-cycle write strobe. The block offers four further controls:
- a one-shot mode, which stops the counter after its first wrap;
- a switch that suppresses update events;
- a selector that limits which sources may set the flag;
- a debug input pair, which freezes counting while a halt is signalled, if freezing is allowed.

Top module: `basic_tmr`

Register word map, selected by `addr`:
- 0: control
- 1: interrupt enable (bit 0)
- 2: status (bit 0 is the update flag)
- 3: event strobe (writing bit 0 as 1 forces an update)
- 4: counter
- 5: prescaler buffer
- 6: reload buffer
- 7: reads zero

## Requirements
- R1: After reset, the register words read as follows: control 0, counter 0, prescaler 0, reload 0xFFFF, status 0. `upd_irq` and `upd_trig` are low.
- R2: In the control word, bit 0 is run, bit 1 is update-disable, bit 2 is overflow-only source, bit 3 is one-shot and bit 7 is reload buffering. Bits 6:4 and all bits above 7 read as zero, whatever was written to them.
- R3: A prescaler value N makes the counter advance once every N+1 clocks while running. A newly written prescaler value takes effect only at the next update event. Word 5 reads back the written value.
- R4: The counter counts 0,1,…,L, where L is the active reload value. On the tick after L it returns to 0 and produces an overflow update event. `upd_trig` is high for exactly the one cycle after each update event.
- R5: With bit 7 clear, a reload write becomes the active limit at once. With bit 7 set, a reload write is held and becomes active only at the next update event. Word 6 reads back the written value.
- R6: In one-shot mode, an overflow update event clears the run bit, and the counter stays at 0.
- R7: With update-disable set, no update event occurs: no flag, no trigger and no buffer load. The counter still wraps at L, and an event strobe still clears the counter and the prescaler.
- R8: With bit 2 set, only overflow sets the flag. With bit 2 clear, an event strobe sets it as well. Either source pulses `upd_trig`.
- R9: The flag stays set until a write to word 2 with bit 0 = 0. If a flag set and a clear fall in the same cycle, the set wins. `upd_irq` equals the flag ANDed with the interrupt enable.
- R10: While `dbg_halt` and `dbg_stop_en` are both high, the counter and the prescaler hold. With `dbg_stop_en` low, the halt input has no effect.
- R11: An event strobe clears the counter and the prescaler in that cycle. It takes priority over a counter write and over a tick in the same cycle. A counter write takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| dbg_halt | input | 1 | Debug halt indication |
| dbg_stop_en | input | 1 | Allow freezing during debug halt |
| upd_irq | output | 1 | Update interrupt request |
| upd_trig | output | 1 | One-cycle update trigger pulse |

## Verification
Assertions check the following on every cycle:
- the counter returns to zero after each overflow;
- the prescaler holds during a permitted debug freeze;
- buffered reload and prescaler values stay unchanged between update events;
- the flag is sticky;
- update-disable silences the trigger;
- one-shot mode clears the run bit.

Only the bench scenarios can show the following:
- the exact division ratio;
- the moment a buffered value takes effect;
- the choice of flag source;
- priority among strobe, counter write and tick.

For these, the bench compares every output against its behavioural model on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_IEN   = 3'd1,
    A_STAT  = 3'd2,
    A_EVGEN = 3'd3,
    A_CNT   = 3'd4,
    A_PSC   = 3'd5,
    A_ARR   = 3'd6,
    A_NONE  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic arpe;
    logic opm;
    logic src;
    logic udis;
    logic run;
  } ctrl_t;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_UDIS = 1;
  localparam int CTRL_SRC  = 2;
  localparam int CTRL_OPM  = 3;
  localparam int CTRL_ARPE = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] pcnt_q, pcnt_d;
  logic         pcnt_ce;
  logic         at_top;

  assign at_top = (pcnt_q == div);
  assign tick   = en && at_top;

  always_comb begin
    pcnt_ce = clr || en;
    pcnt_d  = pcnt_q;
    if (clr)         pcnt_d = '0;
    else if (at_top) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_ce) pcnt_q <= pcnt_d;
  end

  // R10: a frozen, un-cleared prescaler keeps its phase
  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign ovf = tick && !clr && !load && (cnt_q == limit);
  assign cnt = cnt_q;

  always_comb begin
    cnt_ce = clr || load || tick;
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (ovf)  cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R4: the counter returns to zero after an overflow
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         uev,
  input  logic         flag_set,
  input  logic         opm_stop,
  input  logic [W-1:0] cnt,
  output ctrl_t        ctrl,
  output logic         ien,
  output logic         flag,
  output logic [W-1:0] psc_act,
  output logic [W-1:0] arr_act,
  output logic         sw_ug,
  output logic         cnt_wr,
  output logic [W-1:0] rdata
);
  localparam logic [W-1:0] ARR_RST = {W{1'b1}};

  ctrl_t        ctrl_q, ctrl_d;
  logic         ien_q, flag_q, flag_d;
  logic [W-1:0] psc_buf_q, psc_act_q, arr_buf_q, arr_act_q, arr_act_d;
  logic         ctrl_wr, ien_wr, stat_clr, psc_wr, arr_wr;
  logic         ctrl_ce, arr_act_ce, flag_ce;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign ien_wr   = wr_en && (addr == A_IEN);
  assign stat_clr = wr_en && (addr == A_STAT) && !wdata[0];
  assign sw_ug    = wr_en && (addr == A_EVGEN) && wdata[0];
  assign cnt_wr   = wr_en && (addr == A_CNT);
  assign psc_wr   = wr_en && (addr == A_PSC);
  assign arr_wr   = wr_en && (addr == A_ARR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run  = wdata[CTRL_RUN];
      ctrl_d.udis = wdata[CTRL_UDIS];
      ctrl_d.src  = wdata[CTRL_SRC];
      ctrl_d.opm  = wdata[CTRL_OPM];
      ctrl_d.arpe = wdata[CTRL_ARPE];
    end
    if (opm_stop) ctrl_d.run = 1'b0;
    ctrl_ce = ctrl_wr || opm_stop;
  end

  always_comb begin
    arr_act_d  = arr_act_q;
    arr_act_ce = 1'b0;
    if (arr_wr && !ctrl_q.arpe) begin
      arr_act_d  = wdata;
      arr_act_ce = 1'b1;
    end else if (uev) begin
      arr_act_d  = arr_buf_q;
      arr_act_ce = 1'b1;
    end
  end

  always_comb begin
    flag_ce = flag_set || stat_clr;
    flag_d  = flag_set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= 1'b0;
      flag_q    <= 1'b0;
      psc_buf_q <= '0;
      psc_act_q <= '0;
      arr_buf_q <= ARR_RST;
      arr_act_q <= ARR_RST;
    end else begin
      if (ctrl_ce)    ctrl_q    <= ctrl_d;
      if (ien_wr)     ien_q     <= wdata[0];
      if (flag_ce)    flag_q    <= flag_d;
      if (psc_wr)     psc_buf_q <= wdata;
      if (uev)        psc_act_q <= psc_buf_q;
      if (arr_wr)     arr_buf_q <= wdata;
      if (arr_act_ce) arr_act_q <= arr_act_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[CTRL_RUN]  = ctrl_q.run;
        rdata[CTRL_UDIS] = ctrl_q.udis;
        rdata[CTRL_SRC]  = ctrl_q.src;
        rdata[CTRL_OPM]  = ctrl_q.opm;
        rdata[CTRL_ARPE] = ctrl_q.arpe;
      end
      A_IEN:   rdata[0] = ien_q;
      A_STAT:  rdata[0] = flag_q;
      A_CNT:   rdata    = cnt;
      A_PSC:   rdata    = psc_buf_q;
      A_ARR:   rdata    = arr_buf_q;
      default: rdata    = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign ien     = ien_q;
  assign flag    = flag_q;
  assign psc_act = psc_act_q;
  assign arr_act = arr_act_q;

  // R9: the flag is sticky unless software clears it
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_clr) |=> flag_q);
  // R3: the active prescaler changes only at an update event
  assert_psc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(psc_act_q));
  // R5: with buffering on, the active limit waits for an update event
  assert_arr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.arpe && !uev) |=> $stable(arr_act_q));
  // R2: reserved control bits read as zero
  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[6:4] == 3'b000 && rdata[W-1:8] == '0));
endmodule

// File: rtl/basic_tmr.sv
module basic_tmr
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             dbg_halt,
  input  logic             dbg_stop_en,
  output logic             upd_irq,
  output logic             upd_trig
);
  logic         rst_meta, rst_sync;
  ctrl_t        ctrl;
  logic         ien, flag, sw_ug, cnt_wr, tick, ovf, uev, flag_set, opm_stop;
  logic         cnt_en, trig_q;
  logic [CNT_W-1:0] psc_act, arr_act, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign cnt_en   = ctrl.run && !(dbg_halt && dbg_stop_en);
  assign uev      = !ctrl.udis && (sw_ug || ovf);
  assign flag_set = uev && (ovf || !ctrl.src);
  assign opm_stop = uev && ovf && ctrl.opm;

  tmr_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .uev(uev), .flag_set(flag_set), .opm_stop(opm_stop), .cnt(cnt),
    .ctrl(ctrl), .ien(ien), .flag(flag), .psc_act(psc_act), .arr_act(arr_act),
    .sw_ug(sw_ug), .cnt_wr(cnt_wr), .rdata(rdata)
  );

  tmr_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_sync), .en(cnt_en), .clr(sw_ug), .div(psc_act),
    .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .tick(tick), .clr(sw_ug), .load(cnt_wr),
    .load_val(wdata), .limit(arr_act), .cnt(cnt), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) trig_q <= 1'b0;
    else           trig_q <= uev;
  end

  assign upd_trig = trig_q;
  assign upd_irq  = flag && ien;

  // R7: update-disable leaves the trigger silent in the following cycle
  assert_udis_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    ctrl.udis |=> !upd_trig);
  // R6: a one-shot overflow update stops the counter
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (ovf && !ctrl.udis && ctrl.opm) |=> !ctrl.run);
endmodule

// File: tb/basic_tmr_bench.sv
module basic_tmr_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wdata = '0;
  logic        dbg_halt = 1'b0;
  logic        dbg_stop_en = 1'b0;
  logic [15:0] rdata;
  logic        upd_irq, upd_trig;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  bit m_run, m_udis, m_src, m_opm, m_arpe, m_ie, m_flag, m_trig;
  int m_cnt, m_pcnt, m_psc_act, m_psc_buf, m_arr_act, m_arr_buf;

  basic_tmr u_basic_tmr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_halt(dbg_halt), .dbg_stop_en(dbg_stop_en),
    .upd_irq(upd_irq), .upd_trig(upd_trig)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int mread(int a);
    case (a)
      0: return (m_arpe << 7) | (m_opm << 3) | (m_src << 2) | (m_udis << 1) | m_run;
      1: return m_ie;
      2: return m_flag;
      4: return m_cnt;
      5: return m_psc_buf;
      6: return m_arr_buf;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_run, m_udis, m_src, m_opm, m_arpe, m_ie, m_flag, m_trig} = '0;
      m_cnt = 0; m_pcnt = 0; m_psc_act = 0; m_psc_buf = 0;
      m_arr_act = 16'hFFFF; m_arr_buf = 16'hFFFF;
    end else begin
      automatic int  a  = addr;
      automatic int  d  = wdata;
      automatic bit  en = m_run && !(dbg_halt && dbg_stop_en);
      automatic bit  sw = wr_en && a == 3 && d[0];
      automatic bit  cw = wr_en && a == 4;
      automatic bit  tk = en && (m_pcnt == m_psc_act);
      automatic bit  ov = tk && !sw && !cw && (m_cnt == m_arr_act);
      automatic bit  ue = !m_udis && (sw || ov);
      automatic bit  fs = ue && (ov || !m_src);
      automatic bit  old_arpe = m_arpe;
      automatic int  old_pbuf = m_psc_buf;
      automatic int  old_abuf = m_arr_buf;
      if (sw)      m_pcnt = 0;
      else if (en) m_pcnt = (m_pcnt == m_psc_act) ? 0 : m_pcnt + 1;
      if (sw)      m_cnt = 0;
      else if (cw) m_cnt = d;
      else if (tk) m_cnt = ov ? 0 : (m_cnt + 1) % 65536;
      if (ue) m_psc_act = old_pbuf;
      if (wr_en && a == 6 && !old_arpe) m_arr_act = d;
      else if (ue) m_arr_act = old_abuf;
      if (wr_en && a == 6) m_arr_buf = d;
      if (wr_en && a == 5) m_psc_buf = d;
      if (wr_en && a == 0) begin
        m_run = d[0]; m_udis = d[1]; m_src = d[2]; m_opm = d[3]; m_arpe = d[7];
      end
      if (ue && ov && m_opm) m_run = 0;
      if (wr_en && a == 1) m_ie = d[0];
      if (fs) m_flag = 1;
      else if (wr_en && a == 2 && !d[0]) m_flag = 0;
      m_trig = ue;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rdata", rdata, mread(addr));
    chk("upd_irq", upd_irq, m_flag && m_ie);
    chk("upd_trig", upd_trig, m_trig);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, int a);
    addr = a[2:0];
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = a[2:0]; wdata = d[15:0];
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4, 4);
    // R1: reset values of every word
    cur_req = "R1";
    for (int a = 0; a < 8; a++) idle(1, a);
    // R2: control field layout, reserved bits zero
    cur_req = "R2";
    wr(0, 16'hFF7E); idle(1, 0);
    wr(0, 16'h0000); idle(1, 0);
    // R4: wrap at limit 4, divider 1
    cur_req = "R4";
    wr(1, 1); wr(6, 4); wr(0, 16'h0001);
    idle(16, 4);
    // R9: sticky flag, write 1 keeps it, write 0 clears
    cur_req = "R9";
    idle(1, 2); wr(2, 1); idle(1, 2);
    wr(1, 0); idle(1, 2); wr(2, 0); idle(1, 2); wr(1, 1);
    // R3: new divider waits for the update event
    cur_req = "R3";
    wr(5, 2); idle(30, 4); idle(1, 5);
    // R5: buffered vs direct reload
    cur_req = "R5";
    wr(0, 16'h0081); wr(6, 7); idle(40, 4); idle(1, 6);
    wr(0, 16'h0001); wr(6, 2); idle(20, 4);
    // R7: update disable
    cur_req = "R7";
    wr(2, 0); wr(5, 0); wr(0, 16'h0003); idle(12, 4);
    wr(3, 1); idle(6, 4); idle(1, 2);
    // R8: source selection
    cur_req = "R8";
    wr(0, 16'h0004); wr(2, 0); wr(3, 1); idle(3, 2);
    wr(0, 16'h0000); wr(3, 1); idle(3, 2);
    // R10: debug freeze
    cur_req = "R10";
    wr(0, 16'h0001); dbg_halt = 1'b1; idle(6, 4);
    dbg_stop_en = 1'b1; idle(8, 4); dbg_halt = 1'b0; idle(6, 4);
    dbg_stop_en = 1'b0;
    // R6: one-shot stop
    cur_req = "R6";
    wr(6, 5); wr(4, 0); wr(0, 16'h0009); idle(14, 4); idle(1, 0);
    // R11: strobe and counter-write priority
    cur_req = "R11";
    wr(6, 20); wr(0, 16'h0001); idle(5, 4);
    wr(3, 1); idle(3, 4); wr(4, 16'h0011); idle(4, 4);
    wr(5, 3); wr(3, 1); idle(10, 4);
    wr(0, 0); idle(2, 4);
    finish_run();
  end
endmodule